// File: doc/BRIEF.md
# Serially Configured Pad Control Chain

This block is a row of pad control cells, one beside each user pad, linked into a single daisy chain. A serial bit stream is clocked into the chain while a shift enable is high. Each cell hands the bit leaving its own 13-bit shift register to the next cell, and the first cell takes the loader's serial input. A separate load strobe copies every shift register into a shadow register. The shadow register drives that pad's electrical controls, so the pads stay steady while new bits are moving through the chain.

Each cell also picks who drives its pad. When the stored ownership bit is set, the management side drives the pad. Otherwise the user side supplies the pad data and the active-low output enable. The lowest `NUM_BIDIR` cells are full bidirectional management pads: their management side supplies its own output enable. The other cells are selectable pads: their management output enable is ignored and the stored enable bit is used. The value read from each pad always goes back to both sides. A synchronous active-low loader reset puts every cell back to its parameterised default word.

Top module: `pad_ctrl_chain`

## Requirements
- R1: At each rising `clk` edge with `shift_en` high, every cell shifts its word left by one bit and takes in the bit from the previous cell (or `ser_in` for cell 0). `ser_out` is the MSB of the last cell and does not change on edges where `shift_en` is low.
- R2: The first bit shifted in ends up as the MSB of the last cell. After `NUM_PADS`×13 shifts, the stream therefore holds cell `NUM_PADS-1`'s word first, MSB first, and cell 0's word last.
- R3: The pad control outputs change only on a rising edge with `load` high, and then take the shift register contents from before that edge's shift, even when `shift_en` is also high.
- R4: While `ld_rst_n` is low at a rising edge, every shift and shadow register takes its default word and `pad_oeb` goes to all ones. The default for cells below `NUM_BIDIR` is ownership 1, enable bit 0 and drive mode 3'b110. For the other cells it is ownership 1, enable bit 1 and drive mode 3'b001. All remaining bits default to 0.
- R5: Word bit positions, from bit 12 down to bit 0: 12 ownership, 11 output-enable-bar, 10 holdover, 9 input-disable, 8 input-buffer mode, 7 analog enable, 6 analog select, 5 analog polarity, 4 slow slew, 3 trip select, 2:0 drive mode. Cell i's drive mode appears on `pad_dm[3i+2:3i]`.
- R6: When a cell's ownership bit is 1, `pad_out` takes `mgmt_out` one clock later. For cells below `NUM_BIDIR`, `pad_oeb` also takes `mgmt_oeb` one clock later.
- R7: For cells at or above `NUM_BIDIR` with ownership 1, `pad_oeb` equals the stored enable bit (bit 11), and `mgmt_oeb` has no effect.
- R8: When a cell's ownership bit is 0, `pad_out` and `pad_oeb` take `user_out` and `user_oeb` one clock later, and the stored enable bit has no effect.
- R9: `mgmt_in` and `user_in` both equal `pad_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the serial loader and the pad data path |
| ld_rst_n | input | 1 | Synchronous active-low loader reset |
| shift_en | input | 1 | Shift the chain by one bit on this edge |
| ser_in | input | 1 | Serial configuration bit entering cell 0 |
| load | input | 1 | Copy the shift registers into the shadow registers |
| ser_out | output | 1 | MSB of the last cell |
| mgmt_out | input | NUM_PADS | Management pad data |
| mgmt_oeb | input | NUM_PADS | Management active-low output enable |
| mgmt_in | output | NUM_PADS | Pad value returned to management |
| user_out | input | NUM_PADS | User pad data |
| user_oeb | input | NUM_PADS | User active-low output enable |
| user_in | output | NUM_PADS | Pad value returned to the user |
| pad_in | input | NUM_PADS | Value read from the pads |
| pad_out | output | NUM_PADS | Data driven to the pads |
| pad_oeb | output | NUM_PADS | Active-low pad output enable |
| pad_inp_dis | output | NUM_PADS | Input buffer disable |
| pad_ib_mode | output | NUM_PADS | Input buffer mode select |
| pad_vtrip | output | NUM_PADS | Trip point select |
| pad_slow | output | NUM_PADS | Slow slew select |
| pad_holdover | output | NUM_PADS | Holdover control |
| pad_ana_en | output | NUM_PADS | Analog enable |
| pad_ana_sel | output | NUM_PADS | Analog select |
| pad_ana_pol | output | NUM_PADS | Analog polarity |
| pad_dm | output | 3*NUM_PADS | Drive mode, three bits per pad |

## Verification
The hardest case to reach from the ports is `load` and `shift_en` high on the same edge. Here the shadow must capture the words from before the shift, while every shift register moves one place. The bench first fills the chain with known words, then raises both strobes together for one edge and checks the captured fields. It then strobes `load` alone, so the shifted state becomes visible: each cell's word is moved left by one, with the previous cell's MSB carried in. This shows where the chain stood without reading any internal signal.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;

  localparam int CFG_W  = 13;
  localparam int DM_W   = 3;

  // Word layout, MSB first on the serial line
  typedef struct packed {
    logic            own;     // 12
    logic            oeb;     // 11
    logic            hold;    // 10
    logic            indis;   // 9
    logic            ibm;     // 8
    logic            aen;     // 7
    logic            asel;    // 6
    logic            apol;    // 5
    logic            slow;    // 4
    logic            vtrip;   // 3
    logic [DM_W-1:0] dm;      // 2:0
  } pad_cfg_t;

  function automatic pad_cfg_t cfg_default(input logic [DM_W-1:0] dm,
                                           input logic oeb);
    pad_cfg_t c;
    c       = '0;
    c.own   = 1'b1;
    c.oeb   = oeb;
    c.dm    = dm;
    return c;
  endfunction

endpackage

// File: rtl/pad_cfg_shift.sv
module pad_cfg_shift
  import padcfg_pkg::*;
#(
  parameter pad_cfg_t INIT = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     shift_en,
  input  logic     load,
  input  logic     sin,
  output logic     sout,
  output pad_cfg_t cfg
);

  logic [CFG_W-1:0] sr_q;
  pad_cfg_t         shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q     <= INIT;
      shadow_q <= INIT;
    end else begin
      if (load)
        shadow_q <= pad_cfg_t'(sr_q);
      if (shift_en)
        sr_q <= {sr_q[CFG_W-2:0], sin};
    end
  end

  assign sout = sr_q[CFG_W-1];
  assign cfg  = shadow_q;

endmodule

// File: rtl/pad_route.sv
module pad_route #(
  parameter bit FULL_BIDIR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic own,
  input  logic cfg_oeb,
  input  logic mgmt_out,
  input  logic mgmt_oeb,
  input  logic user_out,
  input  logic user_oeb,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oeb,
  output logic mgmt_in,
  output logic user_in
);

  logic mgmt_oe_sel;
  logic nxt_out;
  logic nxt_oeb;

  // Selectable pads take the stored enable; full bidirectional pads take management's
  assign mgmt_oe_sel = FULL_BIDIR ? mgmt_oeb : cfg_oeb;

  always_comb begin
    if (own) begin
      nxt_out = mgmt_out;
      nxt_oeb = mgmt_oe_sel;
    end else begin
      nxt_out = user_out;
      nxt_oeb = user_oeb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_out <= 1'b0;
      pad_oeb <= 1'b1;
      mgmt_in <= 1'b0;
      user_in <= 1'b0;
    end else begin
      pad_out <= nxt_out;
      pad_oeb <= nxt_oeb;
      mgmt_in <= pad_in;
      user_in <= pad_in;
    end
  end

endmodule

// File: rtl/pad_ctrl_cell.sv
module pad_ctrl_cell
  import padcfg_pkg::*;
#(
  parameter pad_cfg_t INIT       = '0,
  parameter bit       FULL_BIDIR = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     shift_en,
  input  logic     load,
  input  logic     sin,
  output logic     sout,
  input  logic     mgmt_out,
  input  logic     mgmt_oeb,
  output logic     mgmt_in,
  input  logic     user_out,
  input  logic     user_oeb,
  output logic     user_in,
  input  logic     pad_in,
  output logic     pad_out,
  output logic     pad_oeb,
  output pad_cfg_t cfg
);

  pad_cfg_t cfg_w;

  pad_cfg_shift #(.INIT(INIT)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .load     (load),
    .sin      (sin),
    .sout     (sout),
    .cfg      (cfg_w)
  );

  pad_route #(.FULL_BIDIR(FULL_BIDIR)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .own      (cfg_w.own),
    .cfg_oeb  (cfg_w.oeb),
    .mgmt_out (mgmt_out),
    .mgmt_oeb (mgmt_oeb),
    .user_out (user_out),
    .user_oeb (user_oeb),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oeb  (pad_oeb),
    .mgmt_in  (mgmt_in),
    .user_in  (user_in)
  );

  assign cfg = cfg_w;

endmodule

// File: rtl/pad_ctrl_chain.sv
module pad_ctrl_chain
  import padcfg_pkg::*;
#(
  parameter int          NUM_PADS        = 4,
  parameter int          NUM_BIDIR       = 2,
  parameter logic [2:0]  BIDIR_DM_INIT   = 3'b110,
  parameter logic        BIDIR_OENB_INIT = 1'b0,
  parameter logic [2:0]  IN_DM_INIT      = 3'b001,
  parameter logic        IN_OENB_INIT    = 1'b1
) (
  input  logic                  clk,
  input  logic                  ld_rst_n,
  input  logic                  shift_en,
  input  logic                  ser_in,
  input  logic                  load,
  output logic                  ser_out,
  input  logic [NUM_PADS-1:0]   mgmt_out,
  input  logic [NUM_PADS-1:0]   mgmt_oeb,
  output logic [NUM_PADS-1:0]   mgmt_in,
  input  logic [NUM_PADS-1:0]   user_out,
  input  logic [NUM_PADS-1:0]   user_oeb,
  output logic [NUM_PADS-1:0]   user_in,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_out,
  output logic [NUM_PADS-1:0]   pad_oeb,
  output logic [NUM_PADS-1:0]   pad_inp_dis,
  output logic [NUM_PADS-1:0]   pad_ib_mode,
  output logic [NUM_PADS-1:0]   pad_vtrip,
  output logic [NUM_PADS-1:0]   pad_slow,
  output logic [NUM_PADS-1:0]   pad_holdover,
  output logic [NUM_PADS-1:0]   pad_ana_en,
  output logic [NUM_PADS-1:0]   pad_ana_sel,
  output logic [NUM_PADS-1:0]   pad_ana_pol,
  output logic [DM_W*NUM_PADS-1:0] pad_dm
);

  logic [NUM_PADS:0]   link;
  logic [NUM_PADS-1:0] own_vec;
  logic [NUM_PADS-1:0] cfg_oeb_vec;

  assign link[0] = ser_in;
  assign ser_out = link[NUM_PADS];

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    localparam bit       IS_BIDIR = (i < NUM_BIDIR);
    localparam pad_cfg_t INIT_W   = IS_BIDIR ? cfg_default(BIDIR_DM_INIT, BIDIR_OENB_INIT)
                                             : cfg_default(IN_DM_INIT, IN_OENB_INIT);
    pad_cfg_t cfg;

    pad_ctrl_cell #(.INIT(INIT_W), .FULL_BIDIR(IS_BIDIR)) u_cell (
      .clk      (clk),
      .rst_n    (ld_rst_n),
      .shift_en (shift_en),
      .load     (load),
      .sin      (link[i]),
      .sout     (link[i+1]),
      .mgmt_out (mgmt_out[i]),
      .mgmt_oeb (mgmt_oeb[i]),
      .mgmt_in  (mgmt_in[i]),
      .user_out (user_out[i]),
      .user_oeb (user_oeb[i]),
      .user_in  (user_in[i]),
      .pad_in   (pad_in[i]),
      .pad_out  (pad_out[i]),
      .pad_oeb  (pad_oeb[i]),
      .cfg      (cfg)
    );

    assign own_vec[i]               = cfg.own;
    assign cfg_oeb_vec[i]           = cfg.oeb;
    assign pad_holdover[i]          = cfg.hold;
    assign pad_inp_dis[i]           = cfg.indis;
    assign pad_ib_mode[i]           = cfg.ibm;
    assign pad_ana_en[i]            = cfg.aen;
    assign pad_ana_sel[i]           = cfg.asel;
    assign pad_ana_pol[i]           = cfg.apol;
    assign pad_slow[i]              = cfg.slow;
    assign pad_vtrip[i]             = cfg.vtrip;
    assign pad_dm[DM_W*i +: DM_W]   = cfg.dm;
  end

endmodule

// File: rtl/pad_ctrl_chain_chk.sv
module pad_ctrl_chain_chk #(
  parameter int         NUM_PADS      = 4,
  parameter int         NUM_BIDIR     = 2,
  parameter logic [2:0] BIDIR_DM_INIT = 3'b110,
  parameter logic [2:0] IN_DM_INIT    = 3'b001
) (
  input logic                  clk,
  input logic                  ld_rst_n,
  input logic                  shift_en,
  input logic                  load,
  input logic                  ser_out,
  input logic [NUM_PADS-1:0]   mgmt_out,
  input logic [NUM_PADS-1:0]   mgmt_oeb,
  input logic [NUM_PADS-1:0]   mgmt_in,
  input logic [NUM_PADS-1:0]   user_out,
  input logic [NUM_PADS-1:0]   user_oeb,
  input logic [NUM_PADS-1:0]   user_in,
  input logic [NUM_PADS-1:0]   pad_in,
  input logic [NUM_PADS-1:0]   pad_out,
  input logic [NUM_PADS-1:0]   pad_oeb,
  input logic [NUM_PADS-1:0]   pad_inp_dis,
  input logic [NUM_PADS-1:0]   pad_ib_mode,
  input logic [NUM_PADS-1:0]   pad_vtrip,
  input logic [NUM_PADS-1:0]   pad_slow,
  input logic [NUM_PADS-1:0]   pad_holdover,
  input logic [NUM_PADS-1:0]   pad_ana_en,
  input logic [NUM_PADS-1:0]   pad_ana_sel,
  input logic [NUM_PADS-1:0]   pad_ana_pol,
  input logic [3*NUM_PADS-1:0] pad_dm,
  input logic [NUM_PADS-1:0]   own_vec,
  input logic [NUM_PADS-1:0]   cfg_oeb_vec
);

  localparam logic [NUM_PADS-1:0] BIDIR_MASK = {NUM_PADS{1'b1}} >> (NUM_PADS - NUM_BIDIR);

  function automatic logic [3*NUM_PADS-1:0] dm_reset_vec();
    logic [3*NUM_PADS-1:0] v;
    for (int i = 0; i < NUM_PADS; i++)
      v[3*i +: 3] = (i < NUM_BIDIR) ? BIDIR_DM_INIT : IN_DM_INIT;
    return v;
  endfunction

  logic seen  = 1'b0;
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    seen  <= 1'b1;
    armed <= ld_rst_n;
  end

  // R1: serial output holds when no shift occurred
  assert_ser_hold_R1: assert property (@(posedge clk) disable iff (!ld_rst_n)
    armed && !$past(shift_en) |-> $stable(ser_out));

  // R3: pad controls hold between load strobes
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!ld_rst_n)
    armed && !$past(load) |-> $stable(pad_dm) && $stable(pad_slow) && $stable(pad_vtrip)
      && $stable(pad_inp_dis) && $stable(pad_ib_mode) && $stable(pad_holdover)
      && $stable(pad_ana_en) && $stable(pad_ana_sel) && $stable(pad_ana_pol));

  // R4: reset defaults
  assert_reset_dflt_R4: assert property (@(posedge clk)
    seen && $past(!ld_rst_n) |-> (pad_dm == dm_reset_vec()) && (pad_oeb == {NUM_PADS{1'b1}}));

  // R6 / R8: pad data follows the owning side
  assert_route_out_R6: assert property (@(posedge clk) disable iff (!ld_rst_n)
    armed |-> pad_out == $past((own_vec & mgmt_out) | (~own_vec & user_out)));

  // R7 / R8: enable source per ownership and cell kind
  assert_route_oeb_R7: assert property (@(posedge clk) disable iff (!ld_rst_n)
    armed |-> pad_oeb == $past((own_vec & BIDIR_MASK & mgmt_oeb)
                             | (own_vec & ~BIDIR_MASK & cfg_oeb_vec)
                             | (~own_vec & user_oeb)));

  // R9: pad value returned to both sides
  assert_pad_return_R9: assert property (@(posedge clk) disable iff (!ld_rst_n)
    armed |-> mgmt_in == $past(pad_in) && user_in == $past(pad_in));

endmodule

bind pad_ctrl_chain pad_ctrl_chain_chk #(
  .NUM_PADS(NUM_PADS), .NUM_BIDIR(NUM_BIDIR),
  .BIDIR_DM_INIT(BIDIR_DM_INIT), .IN_DM_INIT(IN_DM_INIT)
) u_chk (
  .clk(clk), .ld_rst_n(ld_rst_n), .shift_en(shift_en), .load(load), .ser_out(ser_out),
  .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb), .mgmt_in(mgmt_in),
  .user_out(user_out), .user_oeb(user_oeb), .user_in(user_in),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oeb(pad_oeb),
  .pad_inp_dis(pad_inp_dis), .pad_ib_mode(pad_ib_mode), .pad_vtrip(pad_vtrip),
  .pad_slow(pad_slow), .pad_holdover(pad_holdover), .pad_ana_en(pad_ana_en),
  .pad_ana_sel(pad_ana_sel), .pad_ana_pol(pad_ana_pol), .pad_dm(pad_dm),
  .own_vec(own_vec), .cfg_oeb_vec(cfg_oeb_vec)
);

// File: tb/test_pad_ctrl_chain.sv
`timescale 1ns/1ps
module test_pad_ctrl_chain;

  localparam int N  = 4;
  localparam int NB = 2;
  localparam int W  = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ld_rst_n = 1'b0, shift_en = 1'b0, ser_in = 1'b0, load = 1'b0;
  logic ser_out;
  logic [N-1:0] mgmt_out = '0, mgmt_oeb = '0, user_out = '0, user_oeb = '0, pad_in = '0;
  logic [N-1:0] mgmt_in, user_in, pad_out, pad_oeb;
  logic [N-1:0] pad_inp_dis, pad_ib_mode, pad_vtrip, pad_slow, pad_holdover;
  logic [N-1:0] pad_ana_en, pad_ana_sel, pad_ana_pol;
  logic [3*N-1:0] pad_dm;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] words [N];

  pad_ctrl_chain #(.NUM_PADS(N), .NUM_BIDIR(NB)) i_pad_ctrl_chain (
    .clk(clk), .ld_rst_n(ld_rst_n), .shift_en(shift_en), .ser_in(ser_in), .load(load),
    .ser_out(ser_out), .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb), .mgmt_in(mgmt_in),
    .user_out(user_out), .user_oeb(user_oeb), .user_in(user_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oeb(pad_oeb), .pad_inp_dis(pad_inp_dis),
    .pad_ib_mode(pad_ib_mode), .pad_vtrip(pad_vtrip), .pad_slow(pad_slow),
    .pad_holdover(pad_holdover), .pad_ana_en(pad_ana_en), .pad_ana_sel(pad_ana_sel),
    .pad_ana_pol(pad_ana_pol), .pad_dm(pad_dm)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] field(input int pos);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = words[i][pos];
    return v;
  endfunction

  function automatic logic [3*N-1:0] dm_vec();
    logic [3*N-1:0] v;
    for (int i = 0; i < N; i++) v[3*i +: 3] = words[i][2:0];
    return v;
  endfunction

  // R5 bit positions: 12 own, 11 oeb, 10 hold, 9 indis, 8 ibm, 7 aen, 6 asel, 5 apol, 4 slow, 3 vtrip
  task automatic check_fields(input string tag);
    chk({tag, " R5 dm"},      pad_dm,       dm_vec());
    chk({tag, " R5 hold"},    pad_holdover, field(10));
    chk({tag, " R5 indis"},   pad_inp_dis,  field(9));
    chk({tag, " R5 ibm"},     pad_ib_mode,  field(8));
    chk({tag, " R5 aen"},     pad_ana_en,   field(7));
    chk({tag, " R5 asel"},    pad_ana_sel,  field(6));
    chk({tag, " R5 apol"},    pad_ana_pol,  field(5));
    chk({tag, " R5 slow"},    pad_slow,     field(4));
    chk({tag, " R5 vtrip"},   pad_vtrip,    field(3));
  endtask

  // R2: last cell's word first, MSB first
  task automatic shift_in_all();
    for (int k = N-1; k >= 0; k--)
      for (int b = W-1; b >= 0; b--) begin
        ser_in = words[k][b]; shift_en = 1'b1; tick();
      end
    shift_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic pulse_load();
    load = 1'b1; tick(); load = 1'b0;
  endtask

  task automatic test_reset();
    ld_rst_n = 1'b0; mgmt_oeb = '0; user_oeb = '1;
    tick(); tick();
    chk("R4 reset dm", pad_dm, 12'b001_001_110_110);
    chk("R4 reset oeb", pad_oeb, 4'b1111);
    chk("R4 reset ser_out", ser_out, 1'b1);
    ld_rst_n = 1'b1; tick();
    // bidir cells follow mgmt_oeb=0, input cells use stored bit 1
    chk("R4 default oeb routing", pad_oeb, 4'b1100);
  endtask

  task automatic test_load_fields();
    words[0] = 13'b1_0_1_0_1_0_1_0_1_0_101;
    words[1] = 13'b0_1_0_1_0_1_0_1_0_1_010;
    words[2] = 13'b1_0_0_1_1_0_0_1_1_0_011;
    words[3] = 13'b1_1_1_0_0_1_1_0_0_1_100;
    shift_in_all();
    chk("R3 no change before load", pad_dm, 12'b001_001_110_110);
    pulse_load();
    check_fields("R2 load");
    chk("R1 ser_out after fill", ser_out, words[3][12]);
  endtask

  task automatic route_expect(output logic [N-1:0] eo, output logic [N-1:0] ee);
    for (int i = 0; i < N; i++) begin
      if (words[i][12]) begin
        eo[i] = mgmt_out[i];
        ee[i] = (i < NB) ? mgmt_oeb[i] : words[i][11];
      end else begin
        eo[i] = user_out[i];
        ee[i] = user_oeb[i];
      end
    end
  endtask

  task automatic test_routing();
    logic [N-1:0] eo, ee;
    mgmt_out = 4'b0101; mgmt_oeb = 4'b1110; user_out = 4'b1010; user_oeb = 4'b0000;
    route_expect(eo, ee); tick();
    chk("R6 R8 pad_out p1", pad_out, eo);
    chk("R7 R8 pad_oeb p1", pad_oeb, ee);
    mgmt_out = 4'b1010; mgmt_oeb = 4'b0001; user_out = 4'b0101; user_oeb = 4'b1111;
    route_expect(eo, ee); tick();
    chk("R6 R8 pad_out p2", pad_out, eo);
    chk("R7 R8 pad_oeb p2", pad_oeb, ee);
    chk("R7 mgmt_oeb ignored on selectable", pad_oeb[3:2], {words[3][11], words[2][11]});
    chk("R8 stored oeb ignored on user pad", pad_oeb[1], 1'b1);
    user_oeb = 4'b0000; tick();
    chk("R8 user oeb low", pad_oeb[1], 1'b0);
  endtask

  task automatic test_pad_return();
    pad_in = 4'b1001; tick();
    chk("R9 mgmt_in p1", mgmt_in, 4'b1001);
    chk("R9 user_in p1", user_in, 4'b1001);
    pad_in = 4'b0110; tick();
    chk("R9 mgmt_in p2", mgmt_in, 4'b0110);
    chk("R9 user_in p2", user_in, 4'b0110);
  endtask

  task automatic test_hold();
    logic s0;
    s0 = ser_out;
    for (int k = 0; k < 5; k++) begin
      ser_in = k[0]; tick();
      chk("R1 ser_out hold", ser_out, s0);
    end
    pulse_load();
    check_fields("R1 R3 reload unchanged");
  endtask

  task automatic test_same_cycle();
    logic [W-1:0] prev [N];
    for (int i = 0; i < N; i++) prev[i] = words[i];
    ser_in = 1'b1; shift_en = 1'b1; load = 1'b1; tick();
    shift_en = 1'b0; load = 1'b0; ser_in = 1'b0;
    check_fields("R3 pre-shift capture");
    chk("R1 ser_out after one shift", ser_out, prev[3][11]);
    for (int i = 0; i < N; i++)
      words[i] = {prev[i][W-2:0], (i == 0) ? 1'b1 : prev[i-1][W-1]};
    pulse_load();
    check_fields("R1 shifted words");
  endtask

  task automatic test_ser_stream();
    for (int i = 0; i < N; i++) words[i] = 13'h0A5A ^ (13'h0111 * i);
    shift_in_all();
    chk("R1 stream first bit", ser_out, words[3][12]);
    for (int b = 0; b < W; b++) begin
      shift_en = 1'b1; tick();
    end
    shift_en = 1'b0;
    chk("R2 next word msb", ser_out, words[2][12]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick();
    test_reset();
    test_load_fields();
    test_routing();
    test_pad_return();
    test_hold();
    test_same_cycle();
    test_ser_stream();
    test_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule